// File: doc/BRIEF.md
# Carry-Select Wide Adder

This block adds two wide operands and an incoming carry, producing a wide sum and an outgoing carry. It is split into two equal halves. The low half is added once, using the external carry. The high half is added twice at the same time, once assuming no carry arrives from below and once assuming one does. When the real carry out of the low half is known, a two-way multiplexer picks the matching high sum and the matching final carry. The carry therefore never has to ripple through the high half after the low half settles. The only extra delay is one multiplexer level.

The block is purely combinational and has no clock or reset. The half width is a parameter with a default of 32, and the total width is twice that. Each half-width adder is written behaviourally, so synthesis picks its internal structure.

Top module: `cs_wide_adder`

## Requirements
- R1: `sum_out[SW-1:0]` equals the low SW bits of `op_a[SW-1:0] + op_b[SW-1:0] + carry_in`, where SW is the half width (default 32).
- R2: The carry out of the low half, and nothing else, decides which high-half result is used.
- R3: When the low half produces no carry, `sum_out[2*SW-1:SW]` equals the low SW bits of `op_a[2*SW-1:SW] + op_b[2*SW-1:SW]`.
- R4: When the low half produces a carry, `sum_out[2*SW-1:SW]` equals the low SW bits of `op_a[2*SW-1:SW] + op_b[2*SW-1:SW] + 1`.
- R5: `carry_out` equals bit 2*SW of the full-precision sum `op_a + op_b + carry_in`. Combined with R1 to R4, `{carry_out, sum_out}` equals that full-precision sum.
- R6: When one operand is all ones, the other is zero and `carry_in` is 1, or when one operand is all ones, the other is 1 and `carry_in` is 0, `sum_out` is zero and `carry_out` is 1.
- R7: The outputs follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 2*SW | First addend |
| op_b | input | 2*SW | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 2*SW | Sum modulo 2^(2*SW) |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
A wrong carry select shows up at once in the high half of `sum_out`: it is off by exactly one, and `carry_out` may be wrong as well. The low half is unaffected. The bench therefore checks the low half, the high half and the outgoing carry separately on every vector. The vectors are chosen so that the low half both does and does not carry, including all-ones patterns where the carry must pass through every bit. The block has no state, so any fault appears in the same cycle its inputs are applied. The bench also samples shortly after an input change, before any clock edge, to confirm the outputs follow without a clock.

// File: rtl/cs_add_pkg.sv
package cs_add_pkg;
  localparam int unsigned SLICE_W_DEFAULT = 32;

  typedef enum logic {
    SPEC_NO_CARRY = 1'b0,
    SPEC_CARRY    = 1'b1
  } spec_sel_e;
endpackage

// File: rtl/cs_slice_adder.sv
module cs_slice_adder #(
  parameter int unsigned W = cs_add_pkg::SLICE_W_DEFAULT
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  output logic [W-1:0] s_out,
  output logic         c_out
);
  logic [W:0] total;

  always_comb begin
    total = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, c_in};
  end

  assign s_out = total[W-1:0];
  assign c_out = total[W];
endmodule

// File: rtl/cs_upper_select.sv
module cs_upper_select
  import cs_add_pkg::*;
#(
  parameter int unsigned W = SLICE_W_DEFAULT
) (
  input  logic [W-1:0] a_hi,
  input  logic [W-1:0] b_hi,
  input  logic         low_carry,
  output logic [W-1:0] s_hi,
  output logic         c_hi
);
  localparam int unsigned NSPEC = 2;

  logic [W-1:0] spec_sum  [NSPEC];
  logic         spec_cout [NSPEC];
  spec_sel_e    pick;

  for (genvar g = 0; g < NSPEC; g++) begin : g_spec
    cs_slice_adder #(.W(W)) u_slice (
      .a_in  (a_hi),
      .b_in  (b_hi),
      .c_in  (1'(g)),
      .s_out (spec_sum[g]),
      .c_out (spec_cout[g])
    );
  end

  always_comb begin
    pick = spec_sel_e'(low_carry);
    if (pick == SPEC_CARRY) begin
      s_hi = spec_sum[1];
      c_hi = spec_cout[1];
    end else begin
      s_hi = spec_sum[0];
      c_hi = spec_cout[0];
    end
  end

  always_comb begin
    // R4
    spec_pair_chk: assert (spec_sum[1] == spec_sum[0] + W'(1))
      else $error("speculative sums are not one apart");
    // R5
    carry_order_chk: assert (!spec_cout[0] || spec_cout[1])
      else $error("carry without increment but not with increment");
  end
endmodule

// File: rtl/cs_wide_adder.sv
module cs_wide_adder
  import cs_add_pkg::*;
#(
  parameter int unsigned SW = SLICE_W_DEFAULT
) (
  input  logic [2*SW-1:0] op_a,
  input  logic [2*SW-1:0] op_b,
  input  logic            carry_in,
  output logic [2*SW-1:0] sum_out,
  output logic            carry_out
);
  localparam int unsigned TW = 2 * SW;

  logic [SW-1:0] lo_sum;
  logic          lo_carry;
  logic [SW-1:0] hi_sum;
  logic          hi_carry;

  cs_slice_adder #(.W(SW)) u_low (
    .a_in  (op_a[SW-1:0]),
    .b_in  (op_b[SW-1:0]),
    .c_in  (carry_in),
    .s_out (lo_sum),
    .c_out (lo_carry)
  );

  // R2
  cs_upper_select #(.W(SW)) u_high (
    .a_hi      (op_a[TW-1:SW]),
    .b_hi      (op_b[TW-1:SW]),
    .low_carry (lo_carry),
    .s_hi      (hi_sum),
    .c_hi      (hi_carry)
  );

  assign sum_out   = {hi_sum, lo_sum};
  assign carry_out = hi_carry;

  logic [TW:0] chk_total;

  always_comb begin
    chk_total = {1'b0, op_a} + {1'b0, op_b} + {{TW{1'b0}}, carry_in};
    // R5
    full_width_chk: assert ({carry_out, sum_out} == chk_total)
      else $error("wide result mismatch");
    // R6
    wrap_all_chk: assert (!((op_a == ~op_b) && carry_in) || (sum_out == '0 && carry_out))
      else $error("complementary operands with carry did not wrap");
    // R1
    zero_add_chk: assert (!(op_a == '0 && op_b == '0) || (sum_out == TW'(carry_in) && !carry_out))
      else $error("zero operands gave wrong result");
  end
endmodule

// File: tb/tb_cs_wide_adder.sv
module tb_cs_wide_adder;
  localparam int SW = 32;
  localparam int TW = 2 * SW;

  logic          clk;
  logic          rst_n;
  logic [TW-1:0] op_a, op_b, sum_out;
  logic          carry_in, carry_out;
  int            n_checks, n_fail;
  bit            done;

  cs_wide_adder #(.SW(SW)) dut (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_out(sum_out), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [TW:0] act, input logic [TW:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [TW:0] full;
    logic [SW:0] low;
    logic [SW:0] hi_ref;
    full = {1'b0, op_a} + {1'b0, op_b} + {{TW{1'b0}}, carry_in};
    low  = {1'b0, op_a[SW-1:0]} + {1'b0, op_b[SW-1:0]} + {{SW{1'b0}}, carry_in};
    hi_ref = {1'b0, op_a[TW-1:SW]} + {1'b0, op_b[TW-1:SW]} + {{SW{1'b0}}, low[SW]};
    chk("R1", {{(TW-SW+1){1'b0}}, sum_out[SW-1:0]}, {{(TW-SW+1){1'b0}}, low[SW-1:0]});
    if (low[SW])
      chk("R4/R2", {{(TW-SW+1){1'b0}}, sum_out[TW-1:SW]}, {{(TW-SW+1){1'b0}}, hi_ref[SW-1:0]});
    else
      chk("R3/R2", {{(TW-SW+1){1'b0}}, sum_out[TW-1:SW]}, {{(TW-SW+1){1'b0}}, hi_ref[SW-1:0]});
    chk("R5", {{TW{1'b0}}, carry_out}, {{TW{1'b0}}, full[TW]});
  endtask

  task automatic apply(input logic [TW-1:0] a, input logic [TW-1:0] b, input logic c);
    @(posedge clk);
    op_a = a; op_b = b; carry_in = c;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    op_a = '0; op_b = '0; carry_in = 1'b0;
    repeat (2) @(negedge clk);
    // reset-state pattern: zeros in, zeros out (R1, R5)
    chk("R1", {1'b0, sum_out}, '0);
    chk("R5", {{TW{1'b0}}, carry_out}, '0);
    rst_n = 1'b1;

    // R6: all ones plus carry, and all ones plus one
    apply('1, '0, 1'b1);
    chk("R6", {carry_out, sum_out}, {1'b1, {TW{1'b0}}});
    apply('1, TW'(1), 1'b0);
    chk("R6", {carry_out, sum_out}, {1'b1, {TW{1'b0}}});
    // R3: low half carries not, high half full
    apply({{SW{1'b1}}, SW'(5)}, {SW'(1), SW'(7)}, 1'b0);
    // R4: carry only from carry_in through low all-ones
    apply({SW'(3), {SW{1'b1}}}, {SW'(4), SW'(0)}, 1'b1);
    apply({SW'(3), {SW{1'b1}}}, {SW'(4), SW'(0)}, 1'b0);
    // R4 with high half overflowing on the increment
    apply({{SW{1'b1}}, {SW{1'b1}}}, {SW'(0), SW'(1)}, 1'b0);
    apply('1, '1, 1'b1);
    apply('1, '1, 1'b0);

    for (int i = 0; i < 400; i++)
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));

    // R7: outputs follow inputs with no clock edge
    @(posedge clk);
    #2;
    op_a = TW'(64'h0000_0001_ffff_ffff); op_b = TW'(1); carry_in = 1'b0;
    #1;
    chk("R7", {carry_out, sum_out}, {1'b0, TW'(64'h0000_0002_0000_0000)});
    carry_in = 1'b1;
    #1;
    chk("R7", {carry_out, sum_out}, {1'b0, TW'(64'h0000_0002_0000_0001)});
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule